// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer

This block is a 16-bit free-running counter with two output compare channels, programmed over an 8-bit register bus. Each channel keeps a 16-bit compare value, written and read back as a high byte and a low byte. When the counter holds a channel's compare value on a counting tick, the channel raises its status flag. If the channel's output is enabled, its output pin also takes the level programmed for it. An interrupt request is raised while any flag is set, interrupts are enabled and the global mask input is low.

The counter advances on the system clock divided by 2, 4 or 8, or on rising edges of an external clock input. That input is synchronized into the system clock domain first. Software reads the counter as two bytes. Reading the high byte freezes a copy of the low byte, so the two bytes always form one consistent value.

Two ordering rules protect software from races. Writing a compare high byte suspends comparison on that channel until the low byte is written. A flag is cleared only by a status read that sees the flag set, followed later by a read or write of that channel's low compare byte. The bus has no data stream to throttle. Each access is a single-cycle strobe that is always accepted, and the design applies no back-pressure. Read data is combinational in the strobe cycle. Side effects of an access take place at the clock edge that ends that cycle.

Top module: `oc_timer`

Register map (`bus_addr`):

| Addr | Access | Contents |
|------|--------|----------|
| 0 | read/write | control A: bit0 interrupt enable, bit1 channel 0 level, bit2 channel 1 level |
| 1 | read/write | control B: bit0 channel 0 output enable, bit1 channel 1 output enable, bits 3:2 clock select |
| 2 | read only | status: bit0 channel 0 flag, bit1 channel 1 flag |
| 3 / 4 | read/write | channel 0 compare, high byte / low byte |
| 5 / 6 | read/write | channel 1 compare, high byte / low byte |
| 7 / 8 | read only | counter, high byte / latched low byte |

## Requirements
- R1: While `rst_n` is low and directly after it rises, the following hold: both compare values read 0x8000, the counter reads 0xFFFC, status reads 0, `oc_out` is 0 and `irq` is 0.
- R2: The counter advances by exactly one on each tick and wraps from 0xFFFF to 0x0000. With the reset clock select it reads 0x0004 sixteen clocks after reset.
- R3: The clock select field is control B bits 3:2. The value 0 gives one tick per 2 clocks, 1 gives one per 4 clocks, 2 gives one per 8 clocks, and 3 gives one tick per rising edge of `ext_clk`.
- R4: A read of address 7 returns the counter's high byte and latches its low byte. Reads of address 8 return that latched byte until the next high-byte read.
- R5: When the counter equals a channel's compare value on a tick, that channel's status bit is set (bit0 for channel 0, bit1 for channel 1). The counter reads compare+1 right after the match.
- R6: On a match with its output enable set, a channel's `oc_out` bit takes that channel's level bit. With the enable clear, the `oc_out` bit is unchanged. `oc_en` mirrors control B bits 1:0.
- R7: `irq` is high exactly when some status bit is set, control A bit0 is set and `irq_mask` is low.
- R8: A write to a compare high byte stops that channel from matching until its low byte is written.
- R9: A low-byte access (read or write) clears a channel's flag only after a status read that saw the flag set. A low-byte access without such a read leaves the flag set.
- R10: The compare bytes read back exactly the values last written. The counter never changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ext_clk | input | 1 | external count clock, asynchronous |
| irq_mask | input | 1 | global interrupt mask, high blocks `irq` |
| bus_sel | input | 1 | register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | register address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, valid in the strobe cycle |
| oc_out | output | 2 | compare output latches, one per channel |
| oc_en | output | 2 | per-channel indication that the compare drives the pin |
| irq | output | 1 | timer interrupt request |

## Verification
The hardest situations to reach from the ports are a compare that would have matched but was held off by a lone high-byte write, and a flag that survives a low-byte access made without the status read first. The bench reads the live counter and programs a target a few dozen ticks ahead. It leaves a channel inhibited for well past that point, and only then completes the low byte. It watches the flag through `irq` and the output pin rather than the status register, so that polling never arms the clearing handshake by accident. Counting rates are measured from two high-byte reads exactly 64 clocks apart, which yields an exact tick count for every divider.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int CNT_W = 16;
  localparam int BYTE_W = 8;
  localparam int N_CH = 2;
  localparam logic [CNT_W-1:0] CNT_RST = 16'hFFFC;
  localparam logic [CNT_W-1:0] CMP_RST = 16'h8000;

  localparam logic [3:0] A_CTRL_A  = 4'd0;
  localparam logic [3:0] A_CTRL_B  = 4'd1;
  localparam logic [3:0] A_STAT    = 4'd2;
  localparam logic [3:0] A_CMP_HI0 = 4'd3;  // channel i high byte at 3 + 2*i, low byte follows
  localparam logic [3:0] A_CNT_HI  = 4'd7;
  localparam logic [3:0] A_CNT_LO  = 4'd8;

  typedef enum logic [1:0] {
    CK_DIV2 = 2'd0,
    CK_DIV4 = 2'd1,
    CK_DIV8 = 2'd2,
    CK_EXT  = 2'd3
  } ck_sel_e;
endpackage

// File: rtl/oc_tick.sv
module oc_tick
  import oc_pkg::*;
#(
  parameter int PRE_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ck_sel_e sel,
  input  logic    ext_clk,
  output logic    tick
);
  localparam int EXT_W = SYNC_N + 1;

  logic [PRE_W-1:0] div_q;
  logic [EXT_W-1:0] ext_q;
  logic             ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      ext_q <= {ext_q[EXT_W-2:0], ext_clk};
    end
  end

  // last synchronizer stage against the previous sample of it
  assign ext_rise = ext_q[SYNC_N-1] & ~ext_q[SYNC_N];

  always_comb begin
    unique case (sel)
      CK_DIV2: tick = div_q[0];
      CK_DIV4: tick = &div_q[1:0];
      CK_DIV8: tick = &div_q[2:0];
      default: tick = ext_rise;
    endcase
  end

  // R3: an external edge yields a one-cycle enable only
  a_r3_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/oc_counter.sv
module oc_counter
  import oc_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_VAL = CNT_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hi_rd,
  output logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] lo_snap
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RST_VAL;
      snap_q <= RST_VAL[BYTE_W-1:0];
    end else begin
      if (tick)  cnt_q  <= cnt_q + 1'b1;
      if (hi_rd) snap_q <= cnt_q[BYTE_W-1:0];
    end
  end

  assign cnt     = cnt_q;
  assign lo_snap = snap_q;

  // R2: one step per tick, wrapping naturally
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R4: latched byte only moves on a high-byte read
  a_r4_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rd |=> $stable(snap_q));
endmodule

// File: rtl/oc_chan.sv
module oc_chan
  import oc_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_CMP = CMP_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              lo_acc,
  input  logic              stat_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              oe,
  input  logic              lvl,
  output logic [CNT_W-1:0]  cmp,
  output logic              flag,
  output logic              pin
);
  logic [CNT_W-1:0] cmp_q;
  logic inh_q, arm_q, flag_q, pin_q, hit;

  assign hit = tick && (cnt == cmp_q) && !inh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= RST_CMP;
      inh_q  <= 1'b0;
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (wr_hi) begin
        cmp_q[CNT_W-1:BYTE_W] <= wdata;
        inh_q <= 1'b1;
      end else if (wr_lo) begin
        cmp_q[BYTE_W-1:0] <= wdata;
        inh_q <= 1'b0;
      end
      // a new match wins over a clear in the same cycle
      if (hit)                   flag_q <= 1'b1;
      else if (arm_q && lo_acc)  flag_q <= 1'b0;
      if (lo_acc)       arm_q <= 1'b0;
      else if (stat_rd) arm_q <= flag_q;
      if (hit && oe) pin_q <= lvl;
    end
  end

  assign cmp  = cmp_q;
  assign flag = flag_q;
  assign pin  = pin_q;

  // R5: a qualified match always leaves the flag set
  a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R8: no flag rise while inhibited by a high-byte write
  a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(!inh_q));
  // R9: a flag falls only through the armed low-byte access
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q && lo_acc));
  // R6: the pin moves only when the output is enabled
  a_r6_pin_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_q != $past(pin_q)) |-> $past(oe));
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_clk,
  input  logic        irq_mask,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [1:0]  oc_out,
  output logic [1:0]  oc_en,
  output logic        irq
);
  logic             wr, rd, tick;
  logic [2:0]       ctrl_a_q;
  logic [3:0]       ctrl_b_q;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       lo_snap;
  logic [N_CH-1:0]  flag, pin;
  logic [CNT_W-1:0] cmp [N_CH];

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
    end else if (wr) begin
      if (bus_addr == A_CTRL_A) ctrl_a_q <= bus_wdata[2:0];
      if (bus_addr == A_CTRL_B) ctrl_b_q <= bus_wdata[3:0];
    end
  end

  oc_tick u_tick (
    .clk(clk), .rst_n(rst_n), .sel(ck_sel_e'(ctrl_b_q[3:2])),
    .ext_clk(ext_clk), .tick(tick)
  );

  oc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .hi_rd(rd && bus_addr == A_CNT_HI), .cnt(cnt), .lo_snap(lo_snap)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [3:0] HI_A = A_CMP_HI0 + 4'(2 * i);
    localparam logic [3:0] LO_A = HI_A + 4'd1;
    oc_chan u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt),
      .wr_hi(wr && bus_addr == HI_A),
      .wr_lo(wr && bus_addr == LO_A),
      .lo_acc(bus_sel && bus_addr == LO_A),
      .stat_rd(rd && bus_addr == A_STAT),
      .wdata(bus_wdata), .oe(ctrl_b_q[i]), .lvl(ctrl_a_q[1+i]),
      .cmp(cmp[i]), .flag(flag[i]), .pin(pin[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL_A: bus_rdata = {5'd0, ctrl_a_q};
      A_CTRL_B: bus_rdata = {4'd0, ctrl_b_q};
      A_STAT:   bus_rdata = {6'd0, flag};
      4'd3:     bus_rdata = cmp[0][15:8];
      4'd4:     bus_rdata = cmp[0][7:0];
      4'd5:     bus_rdata = cmp[1][15:8];
      4'd6:     bus_rdata = cmp[1][7:0];
      A_CNT_HI: bus_rdata = cnt[15:8];
      A_CNT_LO: bus_rdata = lo_snap;
      default:  bus_rdata = '0;
    endcase
  end

  assign oc_out = pin;
  assign oc_en  = ctrl_b_q[1:0];
  assign irq    = ctrl_a_q[0] & ~irq_mask & (|flag);

  // R10: compare values move only through bus writes
  a_r10_cmp0_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (bus_addr == 4'd3 || bus_addr == 4'd4)) |=> $stable(cmp[0]));
endmodule

// File: tb/oc_timer_bench.sv
module oc_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0, irq_mask = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] oc_out, oc_en;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  oc_timer u_oc_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .irq_mask(irq_mask),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .oc_out(oc_out), .oc_en(oc_en), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    rd(4'd7, h);
    rd(4'd8, l);
    v = {h, l};
  endtask

  task automatic t_reset;
    logic [15:0] c0, c1;
    logic [7:0] b;
    rd_cnt(c0);
    chk("R1 counter reset", c0, 16'hFFFC);
    repeat (14) @(negedge clk);
    rd_cnt(c1);
    chk("R2 wrap after 16 clocks", c1, 16'h0004);
    rd(4'd2, b); chk("R1 status reset", b, 0);
    rd(4'd3, b); chk("R1 cmp0 hi reset", b, 8'h80);
    rd(4'd4, b); chk("R1 cmp0 lo reset", b, 8'h00);
    rd(4'd5, b); chk("R1 cmp1 hi reset", b, 8'h80);
    rd(4'd6, b); chk("R1 cmp1 lo reset", b, 8'h00);
    chk("R1 pins reset", oc_out, 0);
    chk("R1 irq reset", irq, 0);
  endtask

  task automatic t_rate;
    for (int s = 0; s < 3; s++) begin
      logic [15:0] c1, c2, d;
      wr(4'd1, 8'(s << 2));
      rd_cnt(c1);
      repeat (62) @(negedge clk);
      rd_cnt(c2);
      d = c2 - c1;
      chk($sformatf("R3 rate select %0d", s), d, 64 >> (s + 1));
    end
  endtask

  task automatic t_ext;
    logic [15:0] c1, c2;
    wr(4'd1, 8'h0C);
    repeat (4) @(negedge clk);
    rd_cnt(c1);
    for (int k = 0; k < 10; k++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd_cnt(c2);
    chk("R3 external edges", 16'(c2 - c1), 10);
    wr(4'd1, 8'h00);
  endtask

  task automatic t_snapshot;
    logic [7:0] h, l1, l2;
    rd(4'd7, h);
    repeat (20) @(negedge clk);
    rd(4'd8, l1);
    repeat (7) @(negedge clk);
    rd(4'd8, l2);
    chk("R4 latched low byte stable", l2, l1);
  endtask

  task automatic t_match0;
    logic [15:0] c, tgt, now;
    logic [7:0] b;
    int waited;
    wr(4'd0, 8'h03);
    wr(4'd1, 8'h01);
    chk("R6 enable mirror", oc_en, 2'b01);
    rd_cnt(c);
    tgt = c + 16'd30;
    wr(4'd3, tgt[15:8]);
    wr(4'd4, tgt[7:0]);
    rd(4'd3, b); chk("R10 cmp0 hi readback", b, tgt[15:8]);
    rd(4'd4, b); chk("R10 cmp0 lo readback", b, tgt[7:0]);
    chk("R6 pin low before match", oc_out[0], 0);
    waited = 0;
    while (oc_out[0] !== 1'b1 && waited < 200) begin
      @(negedge clk); waited++;
    end
    rd_cnt(now);
    chk("R5 counter after match", now, 16'(tgt + 16'd1));
    chk("R6 pin takes level", oc_out[0], 1);
    chk("R7 irq raised", irq, 1);
    irq_mask = 1'b1; #1;
    chk("R7 irq masked", irq, 0);
    irq_mask = 1'b0;
    wr(4'd0, 8'h02);
    chk("R7 irq disabled", irq, 0);
    wr(4'd0, 8'h03);
    wr(4'd4, tgt[7:0]);
    chk("R9 low write alone keeps flag", irq, 1);
    rd(4'd2, b); chk("R5 status ch0 only", b, 8'h01);
    rd(4'd4, b);
    rd(4'd2, b); chk("R9 flag cleared", b, 8'h00);
    chk("R9 irq dropped", irq, 0);
  endtask

  task automatic t_inhibit1;
    logic [15:0] c, tgt;
    logic [7:0] b;
    int waited;
    wr(4'd0, 8'h05);
    wr(4'd1, 8'h00);
    chk("R6 enables off", oc_en, 2'b00);
    rd_cnt(c);
    tgt = c + 16'd30;
    wr(4'd5, tgt[15:8]);
    wr(4'd6, tgt[7:0]);
    wr(4'd5, tgt[15:8]);
    repeat (100) @(negedge clk);
    chk("R8 no flag while inhibited", irq, 0);
    rd(4'd2, b); chk("R8 status clear while inhibited", b, 8'h00);
    rd_cnt(c);
    tgt = c + 16'd30;
    wr(4'd5, tgt[15:8]);
    wr(4'd6, tgt[7:0]);
    rd(4'd6, b); chk("R10 cmp1 lo readback", b, tgt[7:0]);
    waited = 0;
    while (irq !== 1'b1 && waited < 200) begin
      @(negedge clk); waited++;
    end
    chk("R8 match after low write", irq, 1);
    rd(4'd2, b); chk("R5 status ch1 only", b, 8'h02);
    chk("R6 pin unchanged when disabled", oc_out[1], 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", irq, 0);
    chk("R1 pins in reset", oc_out, 0);
    rst_n = 1'b1;
    t_reset();
    t_rate();
    t_ext();
    t_snapshot();
    t_match0();
    t_inhibit1();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule